// File: doc/BRIEF.md
# Thread Block Dispatcher

This block hands whole thread blocks, taken one at a time from the head of a launch queue, to a row of multiprocessors. For each processor it keeps a small table of the blocks resident there, a resident-block count and a resident-thread count. A block goes to a processor only if that processor is below both its block cap and its thread cap once the new block's threads are added. A block is never split across processors.

The queue head is shown on `req_valid`, `req_threads` and `req_id`. In the same cycle the block answers with `req_take`, which means the head was issued and should be popped, or with `req_drop`, which means the head has an illegal size, is thrown away and should also be popped. If neither is raised, the head waits. One cycle after a take, the chosen processor sees a single-cycle `asg_valid` pulse together with the block id.

When a processor finishes a block it pulses its `done_valid` bit with that block's id. The dispatcher finds the block in its table and frees both the block slot and the thread count the block held.

Top module: `tb_dispatch`

## Requirements
- R1: After reset every processor is empty: `asg_valid` is all zero, and a legal block is taken at once by processor 0.
- R2: A block size is legal from 1 to MAX_BLK_THR threads (512 by default). For a valid request of size 0 or above that limit, `req_drop` is 1 and `req_take` is 0 in the same cycle, no assignment follows, and no processor state changes.
- R3: A legal request goes to the lowest-numbered processor that has room. On the next cycle exactly that processor's `asg_valid` bit is 1, and its `asg_id` slice (bits p*ID_W up to p*ID_W+ID_W-1) carries the request id.
- R4: A processor holds at most MAX_BLK (8) resident blocks. With 64-thread blocks, processor 0 takes eight and the ninth goes to processor 1.
- R5: A processor holds at most MAX_THR (1024) resident threads. With 256-thread blocks, processor 0 takes four and the fifth goes to processor 1. With 512-thread blocks, a processor takes two.
- R6: When no processor fits the head block, `req_take` stays 0 and no assignment is issued. The request keeps waiting.
- R7: A `done_valid` pulse whose id matches a block resident on that processor frees that block's slot and its threads at the next edge. From the following cycle the freed room is available to new requests.
- R8: A `done_valid` pulse whose id is not resident on that processor has no effect.
- R9: An assignment and a release on the same processor can happen in the same cycle, and both take effect. The admission decision in that cycle uses the counts from before the release.
- R10: The resident block and thread counts never exceed their caps and never go below zero. The block count always equals the number of occupied table slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A block is waiting at the queue head |
| req_threads | input | THR_W | Threads in the head block |
| req_id | input | ID_W | Id of the head block |
| req_take | output | 1 | Head block is issued this cycle; pop it |
| req_drop | output | 1 | Head block is illegal; pop and discard it |
| asg_valid | output | NPROC | One-cycle assignment pulse for each processor |
| asg_id | output | NPROC*ID_W | Assigned block id, one slice per processor |
| done_valid | input | NPROC | Completion pulse for each processor |
| done_id | input | NPROC*ID_W | Id of the completed block, one slice per processor |

## Verification
The case that needs care is an admission and a release landing on the same processor in the same cycle. The slot table and both counters must then take the increment and the decrement together, while the admission decision still uses the counts from before the release. The bench sets this up directly: processor 0 is filled to its block cap, a completion on it is raised in the same cycle as a new request, and the bench expects the new block on processor 1 and the next one back on processor 0. The random phase raises completions on many cycles that also carry requests. A bench model checks every take, drop and assignment, and it applies releases before issues in the same way the requirements describe.

// File: rtl/tb_dispatch_pkg.sv
package tb_dispatch_pkg;

  // A block size is admissible when it is non-empty and within the per-block limit.
  function automatic logic size_ok(input int unsigned threads, input int unsigned max_blk_thr);
    return (threads != 0) && (threads <= max_blk_thr);
  endfunction

  // A processor has room when both its block cap and its thread cap still allow the block.
  function automatic logic has_room(input int unsigned blk_cnt, input int unsigned thr_cnt,
                                    input int unsigned threads, input int unsigned max_blk,
                                    input int unsigned max_thr);
    return (blk_cnt < max_blk) && ((thr_cnt + threads) <= max_thr);
  endfunction

endpackage

// File: rtl/tb_pick_lowest.sv
module tb_pick_lowest #(
  parameter int N = 30
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);

  always_comb begin
    gnt = '0;
    any = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        gnt[i] = 1'b1;
        any    = 1'b1;
      end
    end
  end

  a_r3_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  a_r3_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (((gnt - 1'b1) & req) == '0));

  a_r6_no_grant_without_room: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |-> !any);

endmodule

// File: rtl/tb_sm_tracker.sv
module tb_sm_tracker
  import tb_dispatch_pkg::*;
#(
  parameter int MAX_BLK = 8,
  parameter int MAX_THR = 1024,
  parameter int ID_W    = 16,
  parameter int THR_W   = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [THR_W-1:0] req_thr,
  output logic             fit,
  input  logic             issue,
  input  logic [ID_W-1:0]  issue_id,
  input  logic             rel_valid,
  input  logic [ID_W-1:0]  rel_id
);

  localparam int CW = $clog2(MAX_BLK + 1);
  localparam int SW = (MAX_BLK > 1) ? $clog2(MAX_BLK) : 1;

  logic [MAX_BLK-1:0] slot_v;
  logic [ID_W-1:0]    slot_id  [MAX_BLK];
  logic [THR_W-1:0]   slot_thr [MAX_BLK];
  logic [CW-1:0]      blk_cnt;
  logic [THR_W-1:0]   thr_cnt;

  // Named internal events
  logic               rel_hit;
  logic [SW-1:0]      rel_idx;
  logic [SW-1:0]      alloc_idx;
  logic [THR_W-1:0]   rel_thr;

  always_comb begin
    rel_hit = 1'b0;
    rel_idx = '0;
    for (int i = MAX_BLK - 1; i >= 0; i--) begin
      if (slot_v[i] && (slot_id[i] == rel_id)) begin
        rel_hit = rel_valid;
        rel_idx = SW'(i);
      end
    end
  end

  always_comb begin
    alloc_idx = '0;
    for (int i = MAX_BLK - 1; i >= 0; i--) begin
      if (!slot_v[i]) alloc_idx = SW'(i);
    end
  end

  assign rel_thr = rel_hit ? slot_thr[rel_idx] : '0;
  assign fit     = has_room(32'(blk_cnt), 32'(thr_cnt), 32'(req_thr), MAX_BLK, MAX_THR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_v  <= '0;
      blk_cnt <= '0;
      thr_cnt <= '0;
    end else begin
      if (rel_hit) slot_v[rel_idx] <= 1'b0;
      if (issue)   slot_v[alloc_idx] <= 1'b1;
      blk_cnt <= blk_cnt + CW'(issue) - CW'(rel_hit);
      thr_cnt <= thr_cnt + (issue ? req_thr : '0) - rel_thr;
    end
  end

  always_ff @(posedge clk) begin
    if (issue) begin
      slot_id[alloc_idx]  <= issue_id;
      slot_thr[alloc_idx] <= req_thr;
    end
  end

  a_r10_blk_cap: assert property (@(posedge clk) disable iff (!rst_n)
    32'(blk_cnt) <= MAX_BLK);

  a_r10_thr_cap: assert property (@(posedge clk) disable iff (!rst_n)
    32'(thr_cnt) <= MAX_THR);

  a_r10_count_matches_slots: assert property (@(posedge clk) disable iff (!rst_n)
    32'(blk_cnt) == $countones(slot_v));

  a_r4_issue_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> fit);

  a_r8_miss_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && !rel_hit && !issue) |=> ($stable(blk_cnt) && $stable(thr_cnt)));

  a_r7_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_hit && !issue) |=> ((blk_cnt + 1'b1) == $past(blk_cnt)));

  a_r9_both_keep_count: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_hit && issue) |=> $stable(blk_cnt));

endmodule

// File: rtl/tb_dispatch.sv
module tb_dispatch
  import tb_dispatch_pkg::*;
#(
  parameter int NPROC       = 30,
  parameter int MAX_BLK     = 8,
  parameter int MAX_THR     = 1024,
  parameter int MAX_BLK_THR = 512,
  parameter int ID_W        = 16,
  parameter int THR_W       = $clog2(MAX_THR + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [THR_W-1:0]      req_threads,
  input  logic [ID_W-1:0]       req_id,
  output logic                  req_take,
  output logic                  req_drop,
  output logic [NPROC-1:0]      asg_valid,
  output logic [NPROC*ID_W-1:0] asg_id,
  input  logic [NPROC-1:0]      done_valid,
  input  logic [NPROC*ID_W-1:0] done_id
);

  logic             legal;
  logic [NPROC-1:0] fit_vec;
  logic [NPROC-1:0] cand;
  logic [NPROC-1:0] gnt;
  logic             any_gnt;

  assign legal    = size_ok(32'(req_threads), MAX_BLK_THR);
  assign cand     = fit_vec & {NPROC{req_valid & legal}};
  assign req_take = any_gnt;
  assign req_drop = req_valid & ~legal;

  tb_pick_lowest #(.N(NPROC)) pick_i (
    .clk (clk),
    .rst_n (rst_n),
    .req (cand),
    .gnt (gnt),
    .any (any_gnt)
  );

  for (genvar p = 0; p < NPROC; p++) begin : g_proc
    tb_sm_tracker #(
      .MAX_BLK (MAX_BLK),
      .MAX_THR (MAX_THR),
      .ID_W    (ID_W),
      .THR_W   (THR_W)
    ) trk_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_thr   (req_threads),
      .fit       (fit_vec[p]),
      .issue     (gnt[p]),
      .issue_id  (req_id),
      .rel_valid (done_valid[p]),
      .rel_id    (done_id[p*ID_W +: ID_W])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        asg_id[p*ID_W +: ID_W] <= '0;
      end else if (gnt[p]) begin
        asg_id[p*ID_W +: ID_W] <= req_id;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) asg_valid <= '0;
    else        asg_valid <= gnt;
  end

  a_r3_one_assignment: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(asg_valid));

  a_r3_take_then_assign: assert property (@(posedge clk) disable iff (!rst_n)
    req_take |=> ($countones(asg_valid) == 1));

  a_r6_idle_no_assign: assert property (@(posedge clk) disable iff (!rst_n)
    !req_take |=> (asg_valid == '0));

  a_r2_drop_excludes_take: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_take && req_drop));

endmodule

// File: tb/tb_dispatch_tb_top.sv
module tb_dispatch_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NP     = 4;
  localparam int MB     = 8;
  localparam int MT     = 1024;
  localparam int MBT    = 512;
  localparam int IDW    = 16;
  localparam int TW     = $clog2(MT + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [TW-1:0]     req_threads = '0;
  logic [IDW-1:0]    req_id = '0;
  logic              req_take, req_drop;
  logic [NP-1:0]     asg_valid;
  logic [NP*IDW-1:0] asg_id;
  logic [NP-1:0]     done_valid = '0;
  logic [NP*IDW-1:0] done_id = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tb_dispatch #(.NPROC(NP), .MAX_BLK(MB), .MAX_THR(MT), .MAX_BLK_THR(MBT), .ID_W(IDW)) dut_i (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_threads (req_threads),
    .req_id (req_id), .req_take (req_take), .req_drop (req_drop), .asg_valid (asg_valid),
    .asg_id (asg_id), .done_valid (done_valid), .done_id (done_id)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Bench model of each processor's residents
  int m_blk [NP];
  int m_thr [NP];
  bit m_v   [NP][MB];
  int m_id  [NP][MB];
  int m_t   [NP][MB];

  // Completion stimulus staged by callers before a step
  logic [NP-1:0] d_mask;
  int            d_ids [NP];

  task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit legal_sz(input int t);
    return (t >= 1) && (t <= MBT);
  endfunction

  function automatic int exp_proc(input int t);
    for (int p = 0; p < NP; p++)
      if (m_blk[p] < MB && m_thr[p] + t <= MT) return p;
    return -1;
  endfunction

  task automatic model_clear();
    for (int p = 0; p < NP; p++) begin
      m_blk[p] = 0; m_thr[p] = 0;
      for (int s = 0; s < MB; s++) m_v[p][s] = 0;
      d_ids[p] = 0;
    end
    d_mask = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0; done_valid = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_clear();
  endtask

  // One cycle: drive request and staged completions, check take/drop, then the assignment.
  task automatic step(input bit v, input int t, input int id, input string tag);
    int ep;
    bit lg;
    @(negedge clk);
    req_valid   = v;
    req_threads = TW'(t);
    req_id      = IDW'(id);
    done_valid  = d_mask;
    for (int p = 0; p < NP; p++) done_id[p*IDW +: IDW] = IDW'(d_ids[p]);
    #1;
    lg = legal_sz(t);
    ep = (v && lg) ? exp_proc(t) : -1;
    chk(req_take == (ep >= 0), tag, "req_take", req_take, ep >= 0);
    chk(req_drop == (v && !lg), tag, "req_drop", req_drop, v && !lg);
    @(posedge clk);
    #1;
    chk(asg_valid == ((ep >= 0) ? NP'(1) << ep : NP'(0)), tag, "asg_valid", asg_valid,
        (ep >= 0) ? (1 << ep) : 0);
    if (ep >= 0)
      chk(asg_id[ep*IDW +: IDW] == IDW'(id), tag, "asg_id", asg_id[ep*IDW +: IDW], id);
    // model: release first, then issue
    for (int p = 0; p < NP; p++) begin
      if (d_mask[p]) begin
        for (int s = 0; s < MB; s++) begin
          if (m_v[p][s] && m_id[p][s] == d_ids[p]) begin
            m_v[p][s] = 0; m_blk[p]--; m_thr[p] -= m_t[p][s];
            break;
          end
        end
      end
    end
    if (ep >= 0) begin
      for (int s = 0; s < MB; s++) begin
        if (!m_v[ep][s]) begin
          m_v[ep][s] = 1; m_id[ep][s] = id; m_t[ep][s] = t;
          m_blk[ep]++; m_thr[ep] += t;
          break;
        end
      end
    end
    d_mask = '0;
    req_valid = 1'b0;
    done_valid = '0;
  endtask

  int nid = 100;

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_clear();
    do_reset();

    // R1: reset state, then first legal block lands on processor 0
    #1;
    chk(asg_valid == '0, "R1", "asg_valid after reset", asg_valid, 0);
    step(1, 100, nid++, "R1");

    // R2: illegal sizes dropped, boundary 512 taken
    do_reset();
    step(1, 0, nid++, "R2");
    step(1, 513, nid++, "R2");
    step(1, 2000, nid++, "R2");
    step(1, 512, nid++, "R2");
    step(1, 512, nid++, "R2");
    step(1, 1, nid++, "R2");

    // R4: 64-thread blocks, block cap binds
    do_reset();
    for (int i = 0; i < 9; i++) step(1, 64, nid++, "R4");
    chk(m_blk[1] == 1, "R4", "ninth block on processor 1", m_blk[1], 1);

    // R5: 256-thread blocks, then 512-thread blocks
    do_reset();
    for (int i = 0; i < 5; i++) step(1, 256, nid++, "R5");
    chk(m_blk[0] == 4, "R5", "blocks on processor 0", m_blk[0], 4);
    do_reset();
    for (int i = 0; i < 3; i++) step(1, 512, nid++, "R5");

    // R6, R8, R7: fill all with 512-thread blocks, wait, bogus release, real release
    do_reset();
    for (int i = 0; i < 2 * NP; i++) step(1, 512, nid++, "R6");
    for (int i = 0; i < 3; i++) step(1, 512, 7777, "R6");
    d_mask = 4'b0100; d_ids[2] = 60000;
    step(0, 0, 0, "R8");
    step(1, 512, 7777, "R8");
    d_mask = 4'b0100; d_ids[2] = m_id[2][1];
    step(0, 0, 0, "R7");
    step(1, 512, 7778, "R7");

    // R9: same-cycle release and request on a full processor
    do_reset();
    for (int i = 0; i < MB; i++) step(1, 64, nid++, "R9");
    d_mask = 4'b0001; d_ids[0] = m_id[0][3];
    step(1, 64, nid++, "R9");
    chk(m_blk[1] == 1, "R9", "request went to processor 1", m_blk[1], 1);
    step(1, 64, nid++, "R9");
    chk(m_blk[0] == MB, "R9", "processor 0 refilled", m_blk[0], MB);

    // R3, R10: random traffic with releases
    do_reset();
    for (int c = 0; c < 3000; c++) begin
      int t;
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 8) t = (r < 3) ? 0 : int'($urandom_range(513, 2047));
      else if (r < 60) begin
        case ($urandom_range(0, 4))
          0: t = 32; 1: t = 64; 2: t = 128; 3: t = 256; default: t = 512;
        endcase
      end else t = int'($urandom_range(1, 512));
      for (int p = 0; p < NP; p++) begin
        if ($urandom_range(0, 99) < 25) begin
          d_mask[p] = 1'b1;
          d_ids[p] = 60000;
          if ($urandom_range(0, 7) != 0) begin
            for (int s = 0; s < MB; s++) begin
              int k;
              k = (s + int'($urandom_range(0, MB - 1))) % MB;
              if (m_v[p][k]) begin d_ids[p] = m_id[p][k]; break; end
            end
          end
        end
      end
      step($urandom_range(0, 9) != 0, t, nid, "R3");
      nid = (nid >= 50000) ? 100 : nid + 1;
      for (int p = 0; p < NP; p++) begin
        chk(m_blk[p] <= MB && m_thr[p] <= MT && m_blk[p] >= 0, "R10", "model caps", m_blk[p], MB);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule